// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Regulator

This block is the digital half of one bridge's peak-current loop. Whenever the loop is enabled, each on-period starts with the driving diagonal switched on and a blanking interval, during which the current-trip comparator is disregarded so that switching spikes cannot end the on-period early. Once blanking is over, the first trip starts a fixed off-time. The off-time is either pure slow decay or mixed decay. Mixed decay begins in fast decay for a programmed part of the off-time and finishes in slow decay. When the off-time expires, a new on-period starts with a fresh blanking interval.

The block emits a requested bridge state and the latched direction, which a gate sequencer downstream turns into gate signals. All timing advances only on a master-clock tick. That tick comes either from an internal oscillator pulse or from an external clock pulse divided by 1, 2 or 4. The comparator, the current DAC and the reference are outside the block. The block only sees the level code, which must be non-zero to run, and the trip input.

Top module: `pcr_regulator`

## Requirements
- R1: While `run_i` is low, and after reset, `bridge_o` reads 0 (all switches off) from the next clock edge onward. This holds even in the middle of a decay.
- R2: While `level_i` is zero, `bridge_o` stays 0, whatever the other inputs are.
- R3: Each on-period begins with `blank_o`=1 and `bridge_o`=1 (drive) for 4, 6, 8 or 12 ticks, for `blank_code_i` 0, 1, 2 and 3. After that, `bridge_o` stays 1 with `blank_o`=0 until a trip arrives.
- R4: A trip during blanking neither shortens blanking nor starts decay. A trip seen on a tick after blanking starts the off-time on that tick, so drive lasts exactly one tick when the trip is held high.
- R5: The off-time lasts (1+n)*8-1 ticks, where n is `off_code_i` (0..31).
- R6: With `force_slow_i`=0, the off-time starts with `bridge_o`=2 (fast decay) for (1+m)*8-1 ticks, where m is `fast_code_i`. The rest of the off-time is `bridge_o`=3 (slow decay).
- R7: If the fast-decay span is at least the off-time, the whole off-time is fast decay.
- R8: With `force_slow_i`=1, the whole off-time is slow decay and fast decay never appears.
- R9: A change of `dir_i` while driving restarts blanking at full length, and `dir_o` follows `dir_i` on every tick.
- R10: `clk_sel_i` 0 takes ticks from `osc_tick_i`. Codes 1, 2 and 3 take every 1st, 2nd or 4th pulse of `ext_tick_i`. State changes only on a tick.
- R11: When the off-time expires, the block returns to drive with a new blanking interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 2 | Tick source: 0 oscillator, 1/2/3 external divided by 1/2/4 |
| osc_tick_i | input | 1 | One-cycle pulse from the internal oscillator |
| ext_tick_i | input | 1 | One-cycle pulse per external clock period |
| run_i | input | 1 | 0 forces idle with all switches off |
| level_i | input | 6 | Current level code; zero disables the bridge |
| dir_i | input | 1 | Requested current direction |
| force_slow_i | input | 1 | 1 forces pure slow decay |
| off_code_i | input | 5 | Off-time code n |
| fast_code_i | input | 4 | Fast-decay code m |
| blank_code_i | input | 2 | Blanking length code |
| trip_i | input | 1 | Current-trip comparator output |
| bridge_o | output | 2 | Requested bridge state: 0 off, 1 drive, 2 fast decay, 3 slow decay |
| blank_o | output | 1 | High while blanking |
| dir_o | output | 1 | Latched direction for the gate sequencer |

## Verification
Several off-time and fast-decay code pairs are exercised. In one pair the fast span is shorter than the off-time, which exposes the hand-over from fast to slow. In another the fast span is longer, which shows that the off-time end still wins. A third case with slow forced shows that fast decay is skipped entirely. A trip held high through blanking separates a correct blanker from one that samples the comparator too early. A direction flip in the drive phase shows that blanking restarts. Running the same blank code under each tick source shows that every divider ratio stretches the timing by the expected factor.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_BLANK = 3'd1,
      ST_ON    = 3'd2,
      ST_FAST  = 3'd3,
      ST_SLOW  = 3'd4
   } reg_state_e;

   typedef enum logic [1:0] {
      BR_OFF   = 2'd0,
      BR_DRIVE = 2'd1,
      BR_FAST  = 2'd2,
      BR_SLOW  = 2'd3
   } bridge_e;

   // blanking length in ticks per 2-bit code
   function automatic logic [3:0] blank_ticks(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd4;
         2'd1:    return 4'd6;
         2'd2:    return 4'd8;
         default: return 4'd12;
      endcase
   endfunction

endpackage

// File: rtl/pcr_tick_gen.sv
module pcr_tick_gen #(
   parameter int DIV_LOG2_MAX = 2,
   parameter bit HAS_EXT      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel_i,
   input  logic       osc_tick_i,
   input  logic       ext_tick_i,
   output logic       tick_o
);

   localparam int DW = DIV_LOG2_MAX;

   if (DIV_LOG2_MAX != 2) begin : g_bad_div
      $error("pcr_tick_gen: a 2-bit select needs DIV_LOG2_MAX == 2");
   end

   if (HAS_EXT) begin : g_ext
      logic [DW-1:0] div_q;
      logic [DW-1:0] mask;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          div_q <= '0;
         else if (ext_tick_i) div_q <= div_q + DW'(1);
      end

      always_comb begin
         case (sel_i)
            2'b10:   mask = DW'(1);
            2'b11:   mask = DW'(3);
            default: mask = '0;
         endcase
      end

      assign tick_o = (sel_i == 2'b00) ? osc_tick_i
                                       : (ext_tick_i && ((div_q & mask) == mask));
   end else begin : g_osc
      assign tick_o = osc_tick_i;
   end

endmodule

// File: rtl/pcr_span_calc.sv
module pcr_span_calc
   import pcr_pkg::*;
#(
   parameter int OFF_CODE_W  = 5,
   parameter int FAST_CODE_W = 4,
   parameter int CNT_W       = OFF_CODE_W + 3
) (
   input  logic [OFF_CODE_W-1:0]  off_code_i,
   input  logic [FAST_CODE_W-1:0] fast_code_i,
   input  logic [1:0]             blank_code_i,
   output logic [CNT_W-1:0]       off_last_o,
   output logic [CNT_W-1:0]       fast_last_o,
   output logic [CNT_W-1:0]       blank_last_o
);

   if (CNT_W < OFF_CODE_W + 3) begin : g_bad_cnt
      $error("pcr_span_calc: CNT_W too narrow for the off-time");
   end

   // span = (1+code)*8-1 ticks, last index = code*8+6
   assign off_last_o   = CNT_W'({off_code_i, 3'b110});
   assign fast_last_o  = CNT_W'({fast_code_i, 3'b110});
   assign blank_last_o = CNT_W'(blank_ticks(blank_code_i) - 4'd1);

endmodule

// File: rtl/pcr_regulator.sv
module pcr_regulator
   import pcr_pkg::*;
#(
   parameter int LEVEL_W     = 6,
   parameter int OFF_CODE_W  = 5,
   parameter int FAST_CODE_W = 4,
   parameter bit HAS_EXT     = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             clk_sel_i,
   input  logic                   osc_tick_i,
   input  logic                   ext_tick_i,
   input  logic                   run_i,
   input  logic [LEVEL_W-1:0]     level_i,
   input  logic                   dir_i,
   input  logic                   force_slow_i,
   input  logic [OFF_CODE_W-1:0]  off_code_i,
   input  logic [FAST_CODE_W-1:0] fast_code_i,
   input  logic [1:0]             blank_code_i,
   input  logic                   trip_i,
   output logic [1:0]             bridge_o,
   output logic                   blank_o,
   output logic                   dir_o
);

   localparam int CNT_W = OFF_CODE_W + 3;

   if (FAST_CODE_W > OFF_CODE_W) begin : g_bad_fast
      $error("pcr_regulator: fast-decay code wider than off-time code");
   end

   logic             tick;
   logic [CNT_W-1:0] off_last, fast_last, blank_last;
   reg_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             dir_q;
   logic             dir_chg;
   logic             enabled;

   pcr_tick_gen #(.DIV_LOG2_MAX(2), .HAS_EXT(HAS_EXT)) i_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (clk_sel_i),
      .osc_tick_i (osc_tick_i),
      .ext_tick_i (ext_tick_i),
      .tick_o     (tick)
   );

   pcr_span_calc #(.OFF_CODE_W(OFF_CODE_W), .FAST_CODE_W(FAST_CODE_W), .CNT_W(CNT_W)) i_span (
      .off_code_i   (off_code_i),
      .fast_code_i  (fast_code_i),
      .blank_code_i (blank_code_i),
      .off_last_o   (off_last),
      .fast_last_o  (fast_last),
      .blank_last_o (blank_last)
   );

   assign enabled = run_i && (level_i != '0);
   assign dir_chg = dir_i != dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         cnt_q   <= '0;
         dir_q   <= 1'b0;
      end else if (!enabled) begin
         state_q <= ST_OFF;
         cnt_q   <= '0;
         dir_q   <= dir_i;
      end else if (tick) begin
         dir_q <= dir_i;
         case (state_q)
            ST_OFF: begin
               state_q <= ST_BLANK;
               cnt_q   <= '0;
            end
            ST_BLANK: begin
               if (dir_chg) begin
                  cnt_q <= '0;
               end else if (cnt_q == blank_last) begin
                  state_q <= ST_ON;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_ON: begin
               cnt_q <= '0;
               if (dir_chg)     state_q <= ST_BLANK;
               else if (trip_i) state_q <= force_slow_i ? ST_SLOW : ST_FAST;
            end
            ST_FAST: begin
               if (cnt_q == off_last) begin
                  state_q <= ST_BLANK;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
                  if (cnt_q == fast_last) state_q <= ST_SLOW;
               end
            end
            ST_SLOW: begin
               if (cnt_q == off_last) begin
                  state_q <= ST_BLANK;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: begin
               state_q <= ST_OFF;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   always_comb begin
      case (state_q)
         ST_BLANK, ST_ON: bridge_o = BR_DRIVE;
         ST_FAST:         bridge_o = BR_FAST;
         ST_SLOW:         bridge_o = BR_SLOW;
         default:         bridge_o = BR_OFF;
      endcase
   end

   assign blank_o = (state_q == ST_BLANK);
   assign dir_o   = dir_q;

   assert_idle_forces_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> state_q == ST_OFF);

   assert_zero_level_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (level_i == '0) |=> bridge_o == BR_OFF);

   assert_blank_never_decays_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BLANK) |=> !(state_q inside {ST_FAST, ST_SLOW}));

   assert_fast_not_to_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FAST) |=> state_q != ST_ON);

   assert_forced_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ON && force_slow_i) |=> state_q != ST_FAST);

   assert_tick_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && enabled) |=> $stable(state_q));

endmodule

// File: tb/test_pcr_regulator.sv
module test_pcr_regulator;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] clk_sel = 2'd0;
   logic       osc_tick = 1'b1;
   logic       ext_tick = 1'b0;
   logic       run = 1'b0;
   logic [5:0] level = 6'd10;
   logic       dir = 1'b0;
   logic       force_slow = 1'b0;
   logic [4:0] off_code = 5'd1;
   logic [3:0] fast_code = 4'd0;
   logic [1:0] blank_code = 2'd0;
   logic       trip = 1'b0;
   logic [1:0] bridge;
   logic       blank;
   logic       dir_out;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   int n_a, n_b;

   always #2 clk = ~clk;

   pcr_regulator i_pcr_regulator (
      .clk(clk), .rst_n(rst_n), .clk_sel_i(clk_sel), .osc_tick_i(osc_tick),
      .ext_tick_i(ext_tick), .run_i(run), .level_i(level), .dir_i(dir),
      .force_slow_i(force_slow), .off_code_i(off_code), .fast_code_i(fast_code),
      .blank_code_i(blank_code), .trip_i(trip), .bridge_o(bridge),
      .blank_o(blank), .dir_o(dir_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model, states: 0 off,1 blank,2 on,3 fast,4 slow
   int m_st = 0, m_cnt = 0, m_div = 0, m_dir = 0;

   function automatic int blank_len(input int c);
      int t [4] = '{4, 6, 8, 12};
      return t[c];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_div = 0; m_dir = 0;
      end else begin
         bit t;
         int off_t, fast_t, bl;
         if (clk_sel == 0)      t = osc_tick;
         else if (clk_sel == 1) t = ext_tick;
         else if (clk_sel == 2) t = ext_tick && (m_div % 2 == 1);
         else                   t = ext_tick && (m_div == 3);
         if (ext_tick) m_div = (m_div + 1) % 4;
         off_t  = (int'(off_code) + 1) * 8 - 1;
         fast_t = (int'(fast_code) + 1) * 8 - 1;
         bl     = blank_len(int'(blank_code));
         if (!run || level == 0) begin
            m_st = 0; m_cnt = 0; m_dir = int'(dir);
         end else if (t) begin
            bit chg;
            chg = (int'(dir) != m_dir);
            m_dir = int'(dir);
            if (m_st == 0) begin
               m_st = 1; m_cnt = 0;
            end else if (m_st == 1) begin
               if (chg) m_cnt = 0;
               else begin
                  m_cnt++;
                  if (m_cnt == bl) begin m_st = 2; m_cnt = 0; end
               end
            end else if (m_st == 2) begin
               m_cnt = 0;
               if (chg) m_st = 1;
               else if (trip) m_st = force_slow ? 4 : 3;
            end else begin
               m_cnt++;
               if (m_cnt == off_t) begin m_st = 1; m_cnt = 0; end
               else if (m_st == 3 && m_cnt == fast_t) m_st = 4;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int eb;
         eb = (m_st == 0) ? 0 : (m_st <= 2) ? 1 : (m_st == 3) ? 2 : 3;
         chk("R11 model bridge_o", int'(bridge), eb);
         chk("R3 model blank_o", int'(blank), int'(m_st == 1));
         chk("R9 model dir_o", int'(dir_out), m_dir);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   task automatic run_len(input logic [2:0] pat, output int n);
      n = 0;
      while ({bridge, blank} == pat && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic restart();
      @(negedge clk) run = 1'b0;
      @(negedge clk) run = 1'b1;
      @(negedge clk);
   endtask

   localparam logic [2:0] P_BLANK = 3'b011, P_ON = 3'b010,
                          P_FAST = 3'b100, P_SLOW = 3'b110;

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset bridge_o", int'(bridge), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", int'(bridge), 0);

      // R2: zero level keeps the bridge off
      level = 6'd0; run = 1'b1;
      repeat (20) @(negedge clk);
      chk("R2 zero level", int'(bridge), 0);
      level = 6'd10;

      // R3: blank lengths for every code
      for (int c = 0; c < 4; c++) begin
         blank_code = 2'(c);
         restart();
         run_len(P_BLANK, n_a);
         chk("R3 blank length", n_a, blank_len(c));
         chk("R3 drive after blank", int'(bridge), 1);
      end
      blank_code = 2'd0;

      // R4: trip held through blanking
      trip = 1'b1;
      restart();
      run_len(P_BLANK, n_a);
      chk("R4 blank not shortened by trip", n_a, 4);
      run_len(P_ON, n_a);
      chk("R4 drive one tick after blank", n_a, 1);
      trip = 1'b0;

      // R5/R6/R11: mixed decay, fast 7 then slow 8
      off_code = 5'd1; fast_code = 4'd0; force_slow = 1'b0;
      restart();
      run_len(P_BLANK, n_a);
      trip = 1'b1; @(negedge clk); trip = 1'b0;
      run_len(P_FAST, n_a);
      run_len(P_SLOW, n_b);
      chk("R6 fast span", n_a, 7);
      chk("R6 slow remainder", n_b, 8);
      chk("R5 off-time n=1", n_a + n_b, 15);
      chk("R11 blank after off-time", int'(blank), 1);

      // R7: fast span longer than off-time
      off_code = 5'd0; fast_code = 4'd3;
      restart();
      run_len(P_BLANK, n_a);
      trip = 1'b1; @(negedge clk); trip = 1'b0;
      run_len(P_FAST, n_a);
      run_len(P_SLOW, n_b);
      chk("R7 all fast", n_a, 7);
      chk("R7 no slow", n_b, 0);

      // R8: forced slow, off 23
      off_code = 5'd2; fast_code = 4'd0; force_slow = 1'b1;
      restart();
      run_len(P_BLANK, n_a);
      trip = 1'b1; @(negedge clk); trip = 1'b0;
      run_len(P_FAST, n_a);
      run_len(P_SLOW, n_b);
      chk("R8 no fast", n_a, 0);
      chk("R5 R8 slow off-time n=2", n_b, 23);
      force_slow = 1'b0;

      // R5: longest off-time n=31
      off_code = 5'd31; fast_code = 4'd15;
      restart();
      run_len(P_BLANK, n_a);
      trip = 1'b1; @(negedge clk); trip = 1'b0;
      run_len(P_FAST, n_a);
      run_len(P_SLOW, n_b);
      chk("R6 fast span m=15", n_a, 127);
      chk("R5 off-time n=31", n_a + n_b, 255);
      off_code = 5'd1; fast_code = 4'd0;

      // R9: direction change while driving
      restart();
      run_len(P_BLANK, n_a);
      dir = ~dir;
      @(negedge clk);
      chk("R9 dir_o follows", int'(dir_out), int'(dir));
      run_len(P_BLANK, n_a);
      chk("R9 blank restarted", n_a, 4);

      // R1: run low mid-decay
      restart();
      run_len(P_BLANK, n_a);
      trip = 1'b1; @(negedge clk); trip = 1'b0;
      chk("R1 in fast before idle", int'(bridge), 2);
      run = 1'b0;
      @(negedge clk);
      chk("R1 idle mid-decay", int'(bridge), 0);

      // R10: tick sources
      osc_tick = 1'b0; ext_tick = 1'b1;
      clk_sel = 2'd0;
      restart();
      repeat (20) @(negedge clk);
      chk("R10 no osc tick stays off", int'(bridge), 0);
      for (int s = 1; s < 4; s++) begin
         clk_sel = 2'(s);
         @(negedge clk) run = 1'b0;
         @(negedge clk) run = 1'b1;
         while (!blank) @(negedge clk);
         run_len(P_BLANK, n_a);
         chk("R10 divided blank", n_a, 4 * (1 << (s - 1)));
      end

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule